// File: doc/BRIEF.md
# Filtered Reset Sequencer

This block turns a noisy, asynchronous, active-low reset pin into a clean internal reset for the rest of a small controller. The pin is first synchronized, then qualified by a glitch filter. Only a low level that persists for a minimum number of clocks is accepted. Once accepted, the internal reset is raised and held for a guaranteed minimum number of clocks. If the pin is still held low when that time runs out, the reset is held for as long as the pin stays low.

While the internal reset is active, the block also owns the external bus strobes. The data strobe is pinned low, and the address strobe runs as a slow square wave. When the reset ends, a single-cycle start pulse tells the fetch logic to begin. The fixed reset vector is presented on the address output in that same cycle.

The controller has its own power-on reset input, `rst_ni`. It returns the sequencer to the idle state, and it is independent of the filtered pin.

Top module: `rst_sequencer`

## Requirements
- R1: While `rst_ni` is low, and after it is released with the pin high, the outputs are idle: `int_rst_o`=0, `ds_no`=1, `as_no`=1, `start_o`=0, `vector_o`=0.
- R2: A low pulse on `ext_rst_ni` that spans fewer than 4 consecutive rising-edge samples never raises `int_rst_o`.
- R3: When the pin is sampled low on 4 consecutive rising edges, `int_rst_o` rises. The first low sample is at edge P0, so `int_rst_o` is high from edge P0+6 onward. This is the fifth clock after the synchronized low is first seen.
- R4: Once raised, `int_rst_o` stays high for at least 18 clocks. It then falls on the first edge at which the pin, seen through the two-flop synchronizer, is high. A pin sampled high at edge H allows a fall no earlier than edge H+2. For a single pulse of W clocks (W≥4), the high time is max(18, W-4) clocks.
- R5: If the pin returns high before 4 consecutive low samples have been seen, the filter count restarts from zero. For example, the sequence 3 low, 1 high, 3 low produces no reset.
- R6: `ds_no` is low in every cycle in which `int_rst_o` is high.
- R7: During reset, `as_no` starts low in the first reset cycle and then toggles every 2 clocks, giving the pattern 0,0,1,1,0,0,…
- R8: `start_o` is high for exactly one cycle: the first cycle after `int_rst_o` falls. `vector_o` equals 16'h000C in that cycle and is 0 in every other cycle.
- R9: Whenever `int_rst_o` is low, both `ds_no` and `as_no` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset for the sequencer |
| ext_rst_ni | input | 1 | Asynchronous active-low external reset pin |
| int_rst_o | output | 1 | Internal reset, active high |
| ds_no | output | 1 | Data strobe, active low |
| as_no | output | 1 | Address strobe, active low |
| start_o | output | 1 | One-cycle pulse in the first cycle after reset ends |
| vector_o | output | 16 | Reset vector, valid only when start_o is high |

## Verification
The checker watches several rules on every cycle:
- the strobe rules (R6, R7, R9);
- the single-cycle start pulse and its vector gating (R8);
- the minimum stretch, measured with a counter of high cycles (R4).

Some behaviour can only be shown by the bench's pin patterns. This covers the filter threshold and the restart on a glitch (R2, R5), the exact rise latency (R3), and the stretch that follows a long pin hold (R4). The bench predicts the rise and fall cycles for each pattern from the sampled pin history and compares them cycle by cycle.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam logic [ADDR_W-1:0] RESET_VEC = 16'h000C;

  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b1;
          else         chain_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b1;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_filter.sv
module rstseq_filter #(
  parameter int unsigned FILT_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_low_i,
  input  logic active_i,
  output logic arm_o
);
  localparam int unsigned CW = rstseq_pkg::cnt_w(FILT_CLKS);
  localparam logic [CW-1:0] FULL = CW'(FILT_CLKS);
  localparam logic [CW-1:0] LAST = CW'(FILT_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      arm_o <= 1'b0;
    end else begin
      // any high sample restarts qualification
      if (!pin_low_i)         cnt_q <= '0;
      else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      arm_o <= pin_low_i && (cnt_q == LAST) && !active_i;
    end
  end
endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch #(
  parameter int unsigned MIN_CLKS = 18,
  parameter int unsigned AS_HALF  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic pin_low_i,
  output logic active_o,
  output logic ds_no,
  output logic as_no,
  output logic start_o
);
  localparam int unsigned LW = rstseq_pkg::cnt_w(MIN_CLKS);
  localparam int unsigned PW = rstseq_pkg::cnt_w(AS_HALF - 1);
  localparam logic [LW-1:0] LEN_MAX = LW'(MIN_CLKS);
  localparam logic [PW-1:0] PH_LAST = PW'(AS_HALF - 1);

  logic [LW-1:0] len_q;
  logic [PW-1:0] ph_q;
  logic          done;

  assign done = (len_q >= LEN_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      ds_no    <= 1'b1;
      as_no    <= 1'b1;
      start_o  <= 1'b0;
      len_q    <= '0;
      ph_q     <= '0;
    end else begin
      start_o <= 1'b0;
      if (!active_o) begin
        if (arm_i) begin
          active_o <= 1'b1;
          ds_no    <= 1'b0;
          as_no    <= 1'b0;
          len_q    <= LW'(1);
          ph_q     <= '0;
        end
      end else if (done && !pin_low_i) begin
        active_o <= 1'b0;
        ds_no    <= 1'b1;
        as_no    <= 1'b1;
        start_o  <= 1'b1;
        len_q    <= '0;
      end else begin
        if (!done) len_q <= len_q + 1'b1;
        if (ph_q == PH_LAST) begin
          ph_q  <= '0;
          as_no <= ~as_no;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CLKS   = 4,
  parameter int unsigned MIN_CLKS    = 18,
  parameter int unsigned AS_HALF     = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           ext_rst_ni,
  output logic                           int_rst_o,
  output logic                           ds_no,
  output logic                           as_no,
  output logic                           start_o,
  output logic [rstseq_pkg::ADDR_W-1:0]  vector_o
);
  logic pin_sync;
  logic pin_low;
  logic arm;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_rst_ni),
    .q_o   (pin_sync)
  );

  assign pin_low = ~pin_sync;

  rstseq_filter #(.FILT_CLKS(FILT_CLKS)) u_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_low_i(pin_low),
    .active_i (int_rst_o),
    .arm_o    (arm)
  );

  rstseq_stretch #(.MIN_CLKS(MIN_CLKS), .AS_HALF(AS_HALF)) u_stretch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm),
    .pin_low_i(pin_low),
    .active_o (int_rst_o),
    .ds_no    (ds_no),
    .as_no    (as_no),
    .start_o  (start_o)
  );

  assign vector_o = start_o ? rstseq_pkg::RESET_VEC : '0;
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
  parameter int unsigned MIN_CLKS = 18
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          int_rst_o,
  input logic                          ds_no,
  input logic                          as_no,
  input logic                          start_o,
  input logic [rstseq_pkg::ADDR_W-1:0] vector_o
);
  localparam int unsigned HW = rstseq_pkg::cnt_w(MIN_CLKS);
  logic [HW-1:0] high_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 high_cnt <= '0;
    else if (!int_rst_o)                         high_cnt <= '0;
    else if (high_cnt != HW'(MIN_CLKS))          high_cnt <= high_cnt + 1'b1;
  end

  assert_min_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_rst_o) |-> (high_cnt >= HW'(MIN_CLKS)));

  assert_ds_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o |-> !ds_no);

  assert_as_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_rst_o) |-> !as_no);

  assert_as_period_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_rst_o && $past(int_rst_o) && $past(int_rst_o, 2)) |-> (as_no != $past(as_no, 2)));

  assert_idle_strobes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_rst_o |-> (ds_no && as_no));

  assert_start_after_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_rst_o) |-> start_o);

  assert_start_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  assert_vector_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (vector_o == rstseq_pkg::RESET_VEC));

  assert_vector_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> (vector_o == '0));
endmodule

bind rst_sequencer rst_sequencer_chk #(.MIN_CLKS(MIN_CLKS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .int_rst_o(int_rst_o),
  .ds_no    (ds_no),
  .as_no    (as_no),
  .start_o  (start_o),
  .vector_o (vector_o)
);

// File: tb/rst_sequencer_bench.sv
module rst_sequencer_bench;
  localparam int MIN_CLKS = 18;
  localparam int PAT_LEN  = 64;
  localparam int RUN_LEN  = 110;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_rst_ni = 1'b1;
  logic        int_rst_o, ds_no, as_no, start_o;
  logic [15:0] vector_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  rst_sequencer u_rst_sequencer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_rst_ni(ext_rst_ni),
    .int_rst_o (int_rst_o),
    .ds_no     (ds_no),
    .as_no     (as_no),
    .start_o   (start_o),
    .vector_o  (vector_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // pat bit set = pin driven low in that cycle
  function automatic int calc_rise(input logic [PAT_LEN-1:0] pat);
    int run = 0;
    for (int i = 0; i < PAT_LEN; i++) begin
      run = pat[i] ? run + 1 : 0;
      if (run == 4) return i + 4;
    end
    return -1;
  endfunction

  function automatic int calc_fall(input logic [PAT_LEN-1:0] pat, input int rise);
    for (int f = rise + MIN_CLKS; f < RUN_LEN; f++) begin
      if (f - 3 >= PAT_LEN) return f;
      if (!pat[f-3]) return f;
    end
    return RUN_LEN;
  endfunction

  task automatic run_pat(input logic [PAT_LEN-1:0] pat, input string qtag);
    int rise, fall;
    bit e_rst, e_as;
    rise = calc_rise(pat);
    fall = (rise < 0) ? -1 : calc_fall(pat, rise);
    for (int t = 0; t < RUN_LEN; t++) begin
      @(negedge clk_i);
      e_rst = (rise >= 0) && (t >= rise) && (t < fall);
      if (rise < 0)
        check(int_rst_o == e_rst, qtag, int_rst_o, e_rst);
      else if (t < rise || t == rise)
        check(int_rst_o == e_rst, "R3", int_rst_o, e_rst);
      else
        check(int_rst_o == e_rst, "R4", int_rst_o, e_rst);
      if (e_rst) begin
        e_as = ((t - rise) / 2) % 2;
        check(ds_no == 1'b0, "R6", ds_no, 0);
        check(as_no == e_as, "R7", as_no, e_as);
      end else begin
        check(ds_no && as_no, "R9", {ds_no, as_no}, 3);
      end
      check(start_o == (t == fall), "R8", start_o, t == fall);
      check(vector_o == ((t == fall) ? 16'h000C : 16'h0), "R8", vector_o,
            (t == fall) ? 16'h000C : 16'h0);
      ext_rst_ni = (t < PAT_LEN) ? ~pat[t] : 1'b1;
    end
  endtask

  function automatic logic [PAT_LEN-1:0] pulse(input int w);
    logic [PAT_LEN-1:0] p = '0;
    for (int i = 0; i < w && i < PAT_LEN; i++) p[i] = 1'b1;
    return p;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [PAT_LEN-1:0] p;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    // R1: idle while held in power-on reset
    check(int_rst_o == 1'b0 && start_o == 1'b0, "R1", {int_rst_o, start_o}, 0);
    check(ds_no && as_no, "R1", {ds_no, as_no}, 3);
    check(vector_o == 16'h0, "R1", vector_o, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check(int_rst_o == 1'b0 && ds_no && as_no && !start_o, "R1",
          {int_rst_o, ds_no, as_no, start_o}, 6);

    // directed widths around the filter and stretch thresholds
    run_pat(pulse(1), "R2");
    run_pat(pulse(3), "R2");
    run_pat(pulse(4), "R3");
    run_pat(pulse(5), "R3");
    run_pat(pulse(21), "R4");
    run_pat(pulse(22), "R4");
    run_pat(pulse(23), "R4");
    run_pat(pulse(50), "R4");

    // R5: glitch restarts the filter
    run_pat(64'b111_0_111, "R5");
    run_pat(64'b11_0_111_0_11_0_1, "R5");
    // R5: restart then a full qualifying run
    run_pat(64'b1111_0_111, "R5");

    // random single pulses
    for (int k = 0; k < 12; k++) run_pat(pulse(1 + ($urandom % 40)), "R2");

    // random short bursts, each run below the filter threshold
    for (int k = 0; k < 8; k++) begin
      p = '0;
      for (int i = 0; i < 40; i += 5) begin
        int r = $urandom % 4;
        for (int j = 0; j < r; j++) p[i+j] = 1'b1;
      end
      run_pat(p, "R5");
    end

    // R1: power-on reset in the middle of an internal reset
    ext_rst_ni = 1'b0;
    repeat (12) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(int_rst_o == 1'b0 && ds_no && as_no, "R1", {int_rst_o, ds_no, as_no}, 3);
    ext_rst_ni = 1'b1;
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule